// File: doc/BRIEF.md
# Framed Byte-Stream Packet Transmitter

This block turns 104-bit transaction packets from the core into a byte-wide link stream, one byte per beat, with a frame strobe marking each transaction. Every transaction opens with a zero byte and five header bytes that carry the control mode, destination address, size and kind. Payload bytes follow in a fixed order. Physical output cells, pads and clocking sit outside the block, and it serves exactly one packet input.

The core side is a valid/ready channel. A packet transfers on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` may depend on the packet on `in_pkt` (its kind and address), so the source must hold `in_pkt` stable while `in_valid` is high. The source may present a packet at any time and must keep it until it transfers. Two hold inputs arrive from the far end with no known phase: one stops read requests and the other stops writes. Each passes through a two-flop synchronizer. A hold only prevents new packets from starting. A packet already on the link always finishes.

Back-to-back 64-bit writes to consecutive 8-byte addresses can be chained into one long frame that carries no repeated header. Every other transaction boundary drops the frame for at least one beat.

Top module: `lnk_frame_tx`

## Requirements
- R1: After reset, and whenever no transaction is being sent, `lnk_frame` is 0 and `lnk_byte` is 0x00.
- R2: On the beat after an edge that accepts a packet while the link is idle, `lnk_frame` is 1 and `lnk_byte` is 0x00 (beat 0).
- R3: Packet fields are acc=bit 0, wr=bit 1, dmode=bits 3:2 (11 means 64-bit), ctrl=bits 7:4, dst=bits 39:8, data=bits 71:40, src=bits 103:72. Beats 1 to 5 carry {ctrl,dst[31:28]}, dst[27:20], dst[19:12], dst[11:4] and {dst[3:0],dmode,wr,acc}, in that order.
- R4: Beats 6 to 9 carry a 32-bit word, most significant byte first. The word is data for a write (wr=1) and src for a read request (wr=0).
- R5: A read, or a write with dmode other than 11, ends after beat 9. A 64-bit write (wr=1, dmode=11) continues with beats 10 to 13, which carry src (the upper data word), most significant byte first.
- R6: During beat 13 of a 64-bit write, `in_ready` is 1 only if all of these hold: the presented packet is a 64-bit write, its dst equals the current dst plus 8, and the write hold is clear. If that packet is accepted, the frame stays high and the next beat is the new packet's beat 6.
- R7: Outside the case in R6, the frame drops for at least one beat before the next beat 0.
- R8: While a transaction is being sent, `in_ready` is 0, except in the beat-13 slot of R6.
- R9: A synchronized read hold blocks read requests (wr=0) only. A synchronized write hold blocks writes (wr=1) only.
- R10: A hold level present at one clock edge affects `in_ready` only after the following edge, which is a two-edge latency.
- R11: A hold raised while a transaction is in flight does not shorten or pause it. Every frame lasts at least 10 beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet offered by the core |
| in_ready | output | 1 | Block will take the offered packet at this edge |
| in_pkt | input | 104 | Packet fields (see R3) |
| far_rd_hold | input | 1 | Asynchronous far-end hold for read requests |
| far_wr_hold | input | 1 | Asynchronous far-end hold for writes |
| lnk_frame | output | 1 | Frame strobe, high across a transaction |
| lnk_byte | output | 8 | Link byte for the current beat |

## Verification
The assertions assume the core keeps `in_pkt` steady while `in_valid` is high. They also assume the hold inputs change no faster than the synchronizer allows. The bench drives every input just after a falling edge, holds each offered packet until it is taken, and clears the packet to an all-zero read request once the packet transfers. Because of that, `in_ready` during a transaction reflects only the chaining rule and never a stale offer. Random packets mix reads, narrow writes, 64-bit writes and chained bursts. Directed cases cover hold latency, hold independence per kind, holds raised mid-frame, and chaining refused because of a wrong stride or a narrow follower.

// File: rtl/lnk_tx_pkg.sv
package lnk_tx_pkg;

  localparam int PKT_W  = 104;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 4;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] data;
    logic [31:0] dst;
    logic [3:0]  ctrl;
    logic [1:0]  dmode;
    logic        wr;
    logic        acc;
  } pkt_t;

  localparam logic [1:0]       DM_WIDE    = 2'b11;
  localparam logic [IDX_W-1:0] BEAT_SHORT = 4'd9;
  localparam logic [IDX_W-1:0] BEAT_LONG  = 4'd13;
  localparam logic [IDX_W-1:0] BEAT_BODY  = 4'd6;
  localparam logic [IDX_W-1:0] BEAT_UPPER = 4'd10;

  function automatic logic is_wide(pkt_t p);
    return p.wr && (p.dmode == DM_WIDE);
  endfunction

endpackage

// File: rtl/lnk_hold_sync.sv
module lnk_hold_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lnk_byte_mux.sv
module lnk_byte_mux
  import lnk_tx_pkg::*;
(
  input  pkt_t              pkt,
  input  logic [IDX_W-1:0]  idx,
  input  logic              active,
  output logic [BYTE_W-1:0] byte_o
);
  logic [31:0]      lo_word;
  logic [IDX_W-1:0] off;
  logic [1:0]       lane;

  assign lo_word = pkt.wr ? pkt.data : pkt.src;
  assign off     = idx - BEAT_BODY;
  assign lane    = off[1:0];

  function automatic logic [BYTE_W-1:0] pick(logic [31:0] w, logic [1:0] l);
    return w[BYTE_W*(3-int'(l)) +: BYTE_W];
  endfunction

  always_comb begin
    byte_o = '0;
    if (active) begin
      case (idx)
        4'd0:                  byte_o = '0;
        4'd1:                  byte_o = {pkt.ctrl, pkt.dst[31:28]};
        4'd2:                  byte_o = pkt.dst[27:20];
        4'd3:                  byte_o = pkt.dst[19:12];
        4'd4:                  byte_o = pkt.dst[11:4];
        4'd5:                  byte_o = {pkt.dst[3:0], pkt.dmode, pkt.wr, pkt.acc};
        4'd6, 4'd7, 4'd8, 4'd9: byte_o = pick(lo_word, lane);
        4'd10, 4'd11, 4'd12, 4'd13: byte_o = pick(pkt.src, lane);
        default:               byte_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/lnk_seq.sv
module lnk_seq
  import lnk_tx_pkg::*;
#(
  parameter int STRIDE = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  pkt_t             in_pkt,
  input  logic             rd_hold,
  input  logic             wr_hold,
  output logic             in_ready,
  output pkt_t             cur,
  output logic [IDX_W-1:0] idx,
  output logic             active
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  pkt_t             cur_q;
  logic [IDX_W-1:0] last_idx;
  logic             at_last;
  logic             gate;
  logic             chain_ok;
  logic             take;

  assign last_idx = is_wide(cur_q) ? BEAT_LONG : BEAT_SHORT;
  assign at_last  = active_q && (idx_q == last_idx);
  assign gate     = in_pkt.wr ? wr_hold : rd_hold;
  assign chain_ok = at_last && is_wide(cur_q) && is_wide(in_pkt)
                    && (in_pkt.dst == cur_q.dst + 32'(STRIDE));
  assign in_ready = !gate && (!active_q || chain_ok);
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      cur_q    <= '0;
    end else if (take) begin
      cur_q    <= in_pkt;
      active_q <= 1'b1;
      idx_q    <= active_q ? BEAT_BODY : '0;
    end else if (active_q) begin
      if (at_last) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign cur    = cur_q;
  assign idx    = idx_q;
  assign active = active_q;
endmodule

// File: rtl/lnk_frame_tx.sv
module lnk_frame_tx
  import lnk_tx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRIDE      = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [103:0] in_pkt,
  input  logic         far_rd_hold,
  input  logic         far_wr_hold,
  output logic         lnk_frame,
  output logic [7:0]   lnk_byte
);
  logic [1:0]       hold_s;
  logic             rd_hold_s;
  logic             wr_hold_s;
  pkt_t             cur;
  logic [IDX_W-1:0] idx;
  logic             active;

  lnk_hold_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({far_wr_hold, far_rd_hold}),
    .sync_o  (hold_s)
  );

  assign rd_hold_s = hold_s[0];
  assign wr_hold_s = hold_s[1];

  lnk_seq #(.STRIDE(STRIDE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_pkt   (pkt_t'(in_pkt)),
    .rd_hold  (rd_hold_s),
    .wr_hold  (wr_hold_s),
    .in_ready (in_ready),
    .cur      (cur),
    .idx      (idx),
    .active   (active)
  );

  lnk_byte_mux u_mux (
    .pkt    (cur),
    .idx    (idx),
    .active (active),
    .byte_o (lnk_byte)
  );

  assign lnk_frame = active;
endmodule

// File: rtl/lnk_frame_tx_chk.sv
module lnk_frame_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] in_kind,
  input logic       rd_hold_s,
  input logic       wr_hold_s,
  input logic       lnk_frame,
  input logic [7:0] lnk_byte
);
  logic [7:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else if (lnk_frame) run_q <= (run_q == 8'hFF) ? run_q : run_q + 8'd1;
    else run_q <= '0;
  end

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lnk_frame |-> lnk_byte == 8'h00);

  a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !lnk_frame) |=> (lnk_frame && lnk_byte == 8'h00));

  a_r6_chain_wide_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && lnk_frame) |-> (in_kind == 3'b111));

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_frame && run_q < 8'd9) |-> !in_ready);

  a_r9_rd_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_kind[0]) |-> !rd_hold_s);

  a_r9_wr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_kind[0]) |-> !wr_hold_s);

  a_r11_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_frame && run_q < 8'd9) |=> lnk_frame);
endmodule

bind lnk_frame_tx lnk_frame_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_kind   (in_pkt[3:1]),
  .rd_hold_s (rd_hold_s),
  .wr_hold_s (wr_hold_s),
  .lnk_frame (lnk_frame),
  .lnk_byte  (lnk_byte)
);

// File: tb/tb_lnk_frame_tx.sv
module tb_lnk_frame_tx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [103:0] in_pkt = '0;
  logic         far_rd_hold = 1'b0;
  logic         far_wr_hold = 1'b0;
  logic         in_ready;
  logic         lnk_frame;
  logic [7:0]   lnk_byte;
  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  lnk_frame_tx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pkt(in_pkt), .far_rd_hold(far_rd_hold), .far_wr_hold(far_wr_hold),
    .lnk_frame(lnk_frame), .lnk_byte(lnk_byte)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_byte(logic [103:0] p, int k);
    logic [31:0] w;
    int j;
    w = (k >= 10) ? p[103:72] : (p[1] ? p[71:40] : p[103:72]);
    j = (k >= 10) ? k - 10 : k - 6;
    case (k)
      0: return 8'h00;
      1: return {p[7:4], p[39:36]};
      2: return p[35:28];
      3: return p[27:20];
      4: return p[19:12];
      5: return {p[11:8], p[3:0]};
      default: return w[8*(3-j) +: 8];
    endcase
  endfunction

  function automatic int last_of(logic [103:0] p);
    return (p[1] && p[3:2] == 2'b11) ? 13 : 9;
  endfunction

  function automatic logic [103:0] mk(bit wr, logic [1:0] dm, logic [31:0] dst);
    return {$urandom, $urandom, dst, 4'($urandom), dm, wr, 1'b1};
  endfunction

  function automatic string tag_of(int k);
    if (k == 0) return "R2 beat0";
    if (k <= 5) return "R3 header";
    if (k <= 9) return "R4 body";
    return "R5 upper";
  endfunction

  // called just after a falling edge; checks beats and leaves just after the next falling edge
  task automatic run_beats(input logic [103:0] p, input int from, input int upto,
                           input int raise_k);
    for (int k = from; k <= upto; k++) begin
      #1;
      chk(lnk_frame == 1'b1, "R11 frame held", lnk_frame, 1);
      chk(lnk_byte == exp_byte(p, k), tag_of(k), lnk_byte, exp_byte(p, k));
      chk(in_ready == 1'b0, "R8 busy", in_ready, 0);
      if (k == raise_k) begin
        far_rd_hold = 1'b1;
        far_wr_hold = 1'b1;
      end
      @(negedge clk);
    end
  endtask

  task automatic wait_accept(input logic [103:0] p);
    in_valid = 1'b1;
    in_pkt   = p;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_pkt   = '0;
  endtask

  task automatic send(input logic [103:0] p, input int raise_k);
    wait_accept(p);
    run_beats(p, 0, last_of(p), raise_k);
    #1;
    chk(lnk_frame == 1'b0, "R7 gap", lnk_frame, 0);
    chk(lnk_byte == 8'h00, "R1 idle", lnk_byte, 0);
    @(negedge clk);
  endtask

  task automatic send_pair(input logic [103:0] p1, input logic [103:0] p2);
    wait_accept(p1);
    run_beats(p1, 0, 12, -1);
    in_valid = 1'b1;
    in_pkt   = p2;
    #1;
    chk(lnk_byte == exp_byte(p1, 13), "R5 beat13", lnk_byte, exp_byte(p1, 13));
    chk(in_ready == 1'b1, "R6 chain ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    in_pkt   = '0;
    #1;
    chk(lnk_frame == 1'b1 && lnk_byte == exp_byte(p2, 6), "R6 resume",
        {lnk_frame, lnk_byte}, {1'b1, exp_byte(p2, 6)});
    @(negedge clk);
    run_beats(p2, 7, 13, -1);
    #1;
    chk(lnk_frame == 1'b0, "R7 gap after chain", lnk_frame, 0);
    @(negedge clk);
  endtask

  initial begin
    logic [103:0] a, b;
    void'($urandom(32'h1A2B3C4D));
    repeat (3) @(negedge clk);
    #1;
    chk(lnk_frame == 1'b0 && lnk_byte == 8'h00, "R1 in reset", {lnk_frame, lnk_byte}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(lnk_frame == 1'b0 && lnk_byte == 8'h00, "R1 after reset", {lnk_frame, lnk_byte}, 0);
    chk(in_ready == 1'b1, "R1 ready idle", in_ready, 1);
    @(negedge clk);

    // directed kinds
    send(mk(1'b0, 2'b10, 32'h1234_5678), -1);
    send(mk(1'b1, 2'b00, 32'h8000_0001), -1);
    send(mk(1'b1, 2'b11, 32'hFFFF_FFF8), -1);
    a = mk(1'b1, 2'b11, 32'h0000_1000);
    send_pair(a, mk(1'b1, 2'b11, 32'h0000_1008));

    // chaining refused: wrong stride, then narrow follower
    for (int v = 0; v < 2; v++) begin
      a = mk(1'b1, 2'b11, 32'h0400_0000);
      b = (v == 0) ? mk(1'b1, 2'b11, 32'h0400_0010) : mk(1'b1, 2'b10, 32'h0400_0008);
      wait_accept(a);
      run_beats(a, 0, 12, -1);
      in_valid = 1'b1;
      in_pkt   = b;
      #1;
      chk(in_ready == 1'b0, "R6 no chain", in_ready, 0);
      @(negedge clk);
      #1;
      chk(lnk_frame == 1'b0, "R7 drop", lnk_frame, 0);
      chk(in_ready == 1'b1, "R7 idle ready", in_ready, 1);
      @(negedge clk);
      in_valid = 1'b0;
      in_pkt   = '0;
      run_beats(b, 0, last_of(b), -1);
      @(negedge clk);
    end

    // R10 latency and R9 independence
    in_pkt      = mk(1'b0, 2'b10, 32'h55);
    far_rd_hold = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R10 one edge", in_ready, 1);
    @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R10 two edges", in_ready, 0);
    in_pkt = mk(1'b1, 2'b10, 32'h66);
    #1;
    chk(in_ready == 1'b1, "R9 write free", in_ready, 1);
    @(negedge clk);
    send(mk(1'b1, 2'b01, 32'h77), -1);
    a = mk(1'b0, 2'b10, 32'h88);
    in_valid = 1'b1;
    in_pkt   = a;
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(in_ready == 1'b0 && lnk_frame == 1'b0, "R9 read blocked", {in_ready, lnk_frame}, 0);
      @(negedge clk);
    end
    far_rd_hold = 1'b0;
    @(negedge clk);
    #1;
    chk(in_ready == 1'b0, "R10 release lag", in_ready, 0);
    @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R10 released", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    in_pkt   = '0;
    run_beats(a, 0, 9, -1);
    @(negedge clk);

    far_wr_hold = 1'b1;
    repeat (3) @(negedge clk);
    in_pkt = mk(1'b1, 2'b11, 32'h99);
    #1;
    chk(in_ready == 1'b0, "R9 write blocked", in_ready, 0);
    @(negedge clk);
    send(mk(1'b0, 2'b10, 32'hAA), -1);
    far_wr_hold = 1'b0;
    repeat (3) @(negedge clk);

    // R11 hold raised mid-frame
    send(mk(1'b1, 2'b11, 32'hBB0), 3);
    far_rd_hold = 1'b0;
    far_wr_hold = 1'b0;
    repeat (3) @(negedge clk);
    send(mk(1'b0, 2'b00, 32'hCC0), 7);
    far_rd_hold = 1'b0;
    far_wr_hold = 1'b0;
    repeat (3) @(negedge clk);

    // random traffic
    for (int n = 0; n < 150; n++) begin
      int kind;
      kind = int'($urandom % 4);
      if (kind == 0) a = mk(1'b0, 2'($urandom), $urandom);
      else if (kind == 1) a = mk(1'b1, 2'($urandom % 3), $urandom);
      else a = mk(1'b1, 2'b11, $urandom);
      if (kind == 3) send_pair(a, mk(1'b1, 2'b11, a[39:8] + 32'd8));
      else send(a, -1);
      repeat ($urandom % 3) @(negedge clk);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule